// File: doc/BRIEF.md
# Serial DAC Input Register Interface

This block is the digital front end of a 16-bit serial-input converter. A host drives three wires (an active-low select, a serial clock and a data line) plus an optional active-low load strobe. The block samples all of these pins with the system clock and passes them through two-flop synchronizers. It detects edges in the system clock domain. While select is low, it shifts one data bit into an input shift register on each rising serial-clock edge, most significant bit first.

The shift register is copied into the converter holding register in one of two ways, chosen by a parameter. In automatic mode, the copy is made when select returns high. In strobe mode, the copy is made on a falling edge of the load strobe while select is high. The holding register drives the 16-bit converter code. Every change of that code is accompanied by a one-cycle update pulse.

A frame may carry any number of bits. The block keeps the most recent 16. A short frame leaves older bits in place, moved up by the number of new bits. A host that sends fewer bits should therefore pad with zeros at the low end. The holding register clears on reset. The shift register has no reset. The serial clock must run at no more than a quarter of the system clock rate.

Top module: `sdac_frontend`

## Requirements
- R1: After reset the converter code is 0x0000 and the update pulse is low.
- R2: A frame of exactly 16 bits, shifted most significant bit first on rising serial-clock edges while select is low, is presented unchanged as the converter code once it is loaded.
- R3: When a frame carries more than 16 bits, the code keeps only the last 16 bits received (24 bits 0xDE1357 give 0x1357).
- R4: When a frame carries fewer than 16 bits, the older contents move up by the number of new bits and the new bits fill the low end (0x1357 followed by the 8 bits 0x9A gives 0x579A).
- R5: Serial-clock edges while select is high do not change the shift register. A following frame with no bits loads the unchanged contents.
- R6: Each load raises the update pulse for exactly one system clock cycle, and the code changes only in a cycle where the pulse is high.
- R7: In automatic mode, the code is loaded on the rising edge of select and stays unchanged while a frame is still in progress.
- R8: In strobe mode, select rising does not load the code. A falling edge of the active-low load strobe while select is high does load it.
- R9: In strobe mode, a falling edge of the load strobe while select is low is ignored.
- R10: Select may stay low across several host transfers (for example two bytes with a pause in between). Together they form one frame that ends only when select rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_i | input | 1 | Active-low frame select from the host |
| sclk_i | input | 1 | Serial clock; data is taken on its rising edge |
| din_i | input | 1 | Serial data, most significant bit first |
| ld_n_i | input | 1 | Active-low load strobe, used in strobe mode only |
| dac_code_o | output | CODE_W | Converter holding register contents |
| dac_upd_o | output | 1 | One-cycle pulse when the holding register is loaded |

## Verification
The bench drives long frames, short frames, frames with no bits and two-byte frames with a pause inside. A design that counted bits and stopped at 16 would keep the wrong half of a long frame. A design that cleared the shift register at frame start would lose the stale upper bits of a short frame. A design that loaded on a byte boundary would show half a word during the pause. The bench toggles the serial clock with select high. A design that shifted regardless of select would then show altered contents on the next empty frame. The strobe-mode instance receives a strobe while select is low, followed by a select rise. Either one loading by mistake shows up as a wrong code or an extra update pulse.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

    // Raw host pins as sampled by the system clock
    typedef struct packed {
        logic cs_n;
        logic sclk;
        logic din;
        logic ld_n;
    } pin_t;

    localparam int PIN_W = $bits(pin_t);
    localparam pin_t PIN_IDLE = '{cs_n: 1'b1, sclk: 1'b0, din: 1'b0, ld_n: 1'b1};

    // Events detected in the system clock domain
    typedef struct packed {
        logic sclk_rise;
        logic frame_end;
        logic ld_fall;
        logic sel_hi;
        logic din;
    } evt_t;

    typedef enum logic {
        LOAD_STROBE = 1'b0,
        LOAD_AUTO   = 1'b1
    } load_mode_e;

    function automatic logic load_fire(load_mode_e mode, evt_t e);
        if (mode == LOAD_AUTO)
            return e.frame_end;
        return e.ld_fall & e.sel_hi;
    endfunction

    function automatic logic shift_fire(evt_t e);
        return e.sclk_rise & ~e.sel_hi;
    endfunction

endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
    parameter int               W       = 4,
    parameter int               STAGES  = 2,
    parameter logic [W-1:0]     RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    genvar b;
    generate
        for (b = 0; b < W; b++) begin : g_bit
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst)
                    chain <= {STAGES{RST_VAL[b]}};
                else
                    chain <= {chain[STAGES-2:0], d_i[b]};
            end
            assign q_o[b] = chain[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/sdac_edge.sv
module sdac_edge
    import sdac_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  pin_t pins_i,
    output evt_t evt_o
);

    pin_t prev_q;

    always_ff @(posedge clk) begin
        if (rst)
            prev_q <= PIN_IDLE;
        else
            prev_q <= pins_i;
    end

    always_comb begin
        evt_o.sclk_rise = pins_i.sclk & ~prev_q.sclk;
        evt_o.frame_end = pins_i.cs_n & ~prev_q.cs_n;
        evt_o.ld_fall   = ~pins_i.ld_n & prev_q.ld_n;
        evt_o.sel_hi    = pins_i.cs_n;
        evt_o.din       = pins_i.din;
    end

endmodule

// File: rtl/sdac_shift.sv
module sdac_shift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         shift_i,
    input  logic         bit_i,
    output logic [W-1:0] word_o
);

    // No reset: contents are undefined until bits are shifted in
    logic [W-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (shift_i)
            sr_q <= {sr_q[W-2:0], bit_i};
    end

    assign word_o = sr_q;

endmodule

// File: rtl/sdac_hold.sv
module sdac_hold #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] word_i,
    output logic [W-1:0] code_o,
    output logic         upd_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            code_o <= '0;
            upd_o  <= 1'b0;
        end else begin
            upd_o <= load_i;
            if (load_i)
                code_o <= word_i;
        end
    end

endmodule

// File: rtl/sdac_frontend.sv
module sdac_frontend
    import sdac_pkg::*;
#(
    parameter int         CODE_W      = 16,
    parameter int         SYNC_STAGES = 2,
    parameter load_mode_e MODE        = LOAD_AUTO
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n_i,
    input  logic              sclk_i,
    input  logic              din_i,
    input  logic              ld_n_i,
    output logic [CODE_W-1:0] dac_code_o,
    output logic              dac_upd_o
);

    pin_t              raw_pins;
    logic [PIN_W-1:0]  sync_bus;
    pin_t              sync_pins;
    evt_t              evt;
    logic [CODE_W-1:0] shreg;
    logic              do_shift;
    logic              do_load;

    assign raw_pins = '{cs_n: cs_n_i, sclk: sclk_i, din: din_i, ld_n: ld_n_i};

    sdac_sync #(
        .W       (PIN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_IDLE)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (raw_pins),
        .q_o (sync_bus)
    );

    assign sync_pins = pin_t'(sync_bus);

    sdac_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .pins_i (sync_pins),
        .evt_o  (evt)
    );

    assign do_shift = shift_fire(evt);
    assign do_load  = load_fire(MODE, evt);

    sdac_shift #(.W(CODE_W)) u_shift (
        .clk     (clk),
        .shift_i (do_shift),
        .bit_i   (evt.din),
        .word_o  (shreg)
    );

    sdac_hold #(.W(CODE_W)) u_hold (
        .clk    (clk),
        .rst    (rst),
        .load_i (do_load),
        .word_i (shreg),
        .code_o (dac_code_o),
        .upd_o  (dac_upd_o)
    );

endmodule

// File: rtl/sdac_frontend_chk.sv
module sdac_frontend_chk
    import sdac_pkg::*;
#(
    parameter int         CODE_W = 16,
    parameter load_mode_e MODE   = LOAD_AUTO
) (
    input logic              clk,
    input logic              rst,
    input evt_t              evt,
    input logic [CODE_W-1:0] shreg,
    input logic [CODE_W-1:0] code,
    input logic              upd
);

    // R1: held in reset means cleared outputs on the next edge
    p_reset_clear_r1: assert property (@(posedge clk)
        $past(rst) |-> (code == '0 && !upd));

    // R6: the update pulse lasts one cycle
    p_upd_single_r6: assert property (@(posedge clk) disable iff (rst)
        upd |=> !upd);

    // R6: the code never changes silently
    p_code_flagged_r6: assert property (@(posedge clk) disable iff (rst)
        !$stable(code) |-> upd);

    // R5: select high freezes the shift register
    p_sel_hi_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (evt.sel_hi && !$isunknown(shreg)) |=> $stable(shreg));

    generate
        if (MODE == LOAD_AUTO) begin : g_auto
            // R7: a load only follows a select rise
            p_auto_src_r7: assert property (@(posedge clk) disable iff (rst)
                upd |-> $past(evt.frame_end));
        end else begin : g_strobe
            // R8: a load only follows a strobe fall with select high
            p_strobe_src_r8: assert property (@(posedge clk) disable iff (rst)
                upd |-> $past(evt.ld_fall && evt.sel_hi));
            // R9: a strobe fall with select low is ignored
            p_strobe_sel_low_r9: assert property (@(posedge clk) disable iff (rst)
                (evt.ld_fall && !evt.sel_hi) |=> !upd);
        end
    endgenerate

endmodule

bind sdac_frontend sdac_frontend_chk #(
    .CODE_W (CODE_W),
    .MODE   (MODE)
) u_chk (
    .clk   (clk),
    .rst   (rst),
    .evt   (evt),
    .shreg (shreg),
    .code  (dac_code_o),
    .upd   (dac_upd_o)
);

// File: tb/tb_sdac_frontend.sv
module tb_sdac_frontend;
    import sdac_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        din = 1'b0;
    logic        ld_n = 1'b1;
    logic [15:0] code_a, code_s;
    logic        upd_a, upd_s;
    int          n_chk = 0;
    int          n_fail = 0;
    int          cnt_a = 0;
    int          cnt_s = 0;

    always #2 clk = ~clk;   // 250 MHz

    sdac_frontend #(.MODE(LOAD_AUTO)) dut (
        .clk(clk), .rst(rst), .cs_n_i(cs_n), .sclk_i(sclk), .din_i(din),
        .ld_n_i(1'b1), .dac_code_o(code_a), .dac_upd_o(upd_a)
    );

    sdac_frontend #(.MODE(LOAD_STROBE)) dut_ld (
        .clk(clk), .rst(rst), .cs_n_i(cs_n), .sclk_i(sclk), .din_i(din),
        .ld_n_i(ld_n), .dac_code_o(code_s), .dac_upd_o(upd_s)
    );

    always @(posedge clk) begin
        if (!rst && upd_a) cnt_a <= cnt_a + 1;
        if (!rst && upd_s) cnt_s <= cnt_s + 1;
    end

    task automatic check(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sel_low();
        @(negedge clk) cs_n = 1'b0;
        idle(4);
    endtask

    task automatic sel_high();
        @(negedge clk) cs_n = 1'b1;
        idle(10);
    endtask

    task automatic send_bits(logic [31:0] val, int n);
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge clk) din = val[i];
            idle(4);
            sclk = 1'b1;
            idle(8);
            sclk = 1'b0;
            idle(4);
        end
    endtask

    task automatic strobe();
        @(negedge clk) ld_n = 1'b0;
        idle(6);
        ld_n = 1'b1;
        idle(8);
    endtask

    task automatic t_reset();
        check("R1", "auto code", code_a, 0);
        check("R1", "auto upd", upd_a, 0);
        check("R1", "strobe code", code_s, 0);
        check("R1", "strobe upd", upd_s, 0);
    endtask

    task automatic t_full_word();
        sel_low();
        send_bits(32'hA5C3, 16);
        idle(6);
        check("R7", "code mid frame", code_a, 0);
        sel_high();
        check("R2", "auto code", code_a, 16'hA5C3);
        check("R6", "auto pulses", cnt_a, 1);
        check("R8", "strobe code after select rise", code_s, 0);
        check("R8", "strobe pulses", cnt_s, 0);
        strobe();
        check("R8", "strobe code after strobe", code_s, 16'hA5C3);
        check("R6", "strobe pulses", cnt_s, 1);
    endtask

    task automatic t_long();
        sel_low();
        send_bits(32'hDE1357, 24);
        sel_high();
        check("R3", "last 16 kept", code_a, 16'h1357);
        check("R6", "auto pulses", cnt_a, 2);
    endtask

    task automatic t_short();
        sel_low();
        send_bits(32'h9A, 8);
        sel_high();
        check("R4", "stale upper bits", code_a, 16'h579A);
    endtask

    task automatic t_two_bytes();
        sel_low();
        send_bits(32'h3C, 8);
        idle(40);
        check("R10", "code during pause", code_a, 16'h579A);
        check("R10", "pulses during pause", cnt_a, 3);
        send_bits(32'hE1, 8);
        sel_high();
        check("R10", "joined word", code_a, 16'h3CE1);
        check("R10", "one pulse", cnt_a, 4);
        check("R8", "strobe code unchanged", code_s, 16'hA5C3);
    endtask

    task automatic t_ignore_sclk();
        @(negedge clk) din = 1'b1;
        for (int i = 0; i < 8; i++) begin
            idle(4); sclk = 1'b1;
            idle(4); sclk = 1'b0;
        end
        sel_low();
        sel_high();
        check("R5", "empty frame reload", code_a, 16'h3CE1);
        check("R5", "empty frame pulse", cnt_a, 5);
        strobe();
        check("R5", "strobe reload", code_s, 16'h3CE1);
        check("R6", "strobe pulses", cnt_s, 2);
    endtask

    task automatic t_strobe_sel_low();
        sel_low();
        send_bits(32'h0F0F, 16);
        strobe();
        check("R9", "strobe with select low", code_s, 16'h3CE1);
        check("R9", "no pulse", cnt_s, 2);
        sel_high();
        check("R8", "select rise no load", code_s, 16'h3CE1);
        check("R8", "no pulse on select", cnt_s, 2);
        check("R7", "auto loads on select", code_a, 16'h0F0F);
        strobe();
        check("R8", "strobe load", code_s, 16'h0F0F);
        check("R6", "strobe pulses", cnt_s, 3);
        check("R6", "auto pulses", cnt_a, 6);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        idle(2);
        t_reset();
        t_full_word();
        t_long();
        t_short();
        t_two_bytes();
        t_ignore_sclk();
        t_strobe_sel_low();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule